// File: doc/BRIEF.md
# System Clock Gear Divider

This block takes a single base clock and derives three clock-enable strobes from it. The high-speed strobe fires once every 1, 2, 4, 8 or 16 base cycles, chosen by a 3-bit gear code. The peripheral prescaler strobe fires once every 2^n base cycles for n from 0 to 9, chosen by a 4-bit code. The middle-speed strobe fires on every 1st, 2nd, 4th or 8th prescaler strobe, chosen by a 2-bit code. Downstream logic uses each strobe as a synchronous enable in the base clock domain.

Software writes all three selection codes together through one write port. The divider hardware does not switch to a new ratio straight away. Each divider changes ratio only when its current divided period ends, so no output interval is ever cut short. Each divider has a read-only status code that reports the ratio actually running. Software polls the status code until it matches the selection code, and that match confirms the switch is complete. A write that carries a reserved code in one field leaves that field's previous selection in place. Valid codes in the other fields of the same write still take effect.

Top module: `clk_gear_unit`

## Requirements
- R1: After reset, all three selection codes and all three status codes are 0, and `gear_en`, `pre_en` and `mid_en` are high on every base cycle.
- R2: A gear code g from 0 to 4 makes `gear_en` high for one base cycle out of every 2^g, once the gear status equals g.
- R3: A write with a gear code of 5, 6 or 7 leaves `gear_sel`, `gear_stat` and the `gear_en` period unchanged.
- R4: A prescaler code p from 0 to 9 makes `pre_en` high for one base cycle out of every 2^p, once the prescaler status equals p.
- R5: A write with a prescaler code from 10 to 15 leaves `pre_sel`, `pre_stat` and the `pre_en` period unchanged.
- R6: With middle code m (0 to 3), `mid_en` is high on one `pre_en` cycle out of every 2^m. `mid_en` is never high while `pre_en` is low.
- R7: A status code keeps its old value until the base cycle after that stage's strobe. In that following cycle it takes the selection code that was present at the strobe.
- R8: When a ratio change is pending, the interval ending at the next strobe still has the old length. Every interval after that strobe has the new length.
- R9: Each field is accepted or rejected on its own. A reserved code in one field does not stop a valid code in another field of the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the three selection fields |
| cfg_gear | input | 3 | Requested gear code |
| cfg_pre | input | 4 | Requested prescaler code |
| cfg_mid | input | 2 | Requested middle-speed code |
| gear_sel | output | 3 | Accepted gear selection |
| gear_stat | output | 3 | Gear ratio currently in effect |
| pre_sel | output | 4 | Accepted prescaler selection |
| pre_stat | output | 4 | Prescaler ratio currently in effect |
| mid_sel | output | 2 | Accepted middle-speed selection |
| mid_stat | output | 2 | Middle-speed ratio currently in effect |
| gear_en | output | 1 | High-speed clock enable strobe |
| pre_en | output | 1 | Prescaler clock enable strobe |
| mid_en | output | 1 | Middle-speed clock enable strobe |

## Verification
The bench builds the block with its default field widths and code limits. At these values every code of every field can be swept: all eight gear codes, all sixteen prescaler codes and all four middle codes. Every valid code is therefore measured against 2^code, and every reserved code is tried. A mid-period switch from divide-by-16 to divide-by-2 brings the boundary rule within reach. It checks the lagging status and the unshortened final interval cycle by cycle.

// File: rtl/clk_gear_pkg.sv
package clk_gear_pkg;

  localparam int unsigned GEAR_W       = 3;
  localparam int unsigned GEAR_MAXCODE = 4;
  localparam int unsigned PRE_W        = 4;
  localparam int unsigned PRE_MAXCODE  = 9;
  localparam int unsigned MID_W        = 2;
  localparam int unsigned MID_MAXCODE  = 3;

  // A code is usable when it does not exceed the largest defined code.
  function automatic bit code_ok(input int unsigned code, input int unsigned maxc);
    return code <= maxc;
  endfunction

  // Terminal count of a power-of-two divider: 2^code - 1.
  function automatic int unsigned term_count(input int unsigned code);
    return (32'd1 << code) - 32'd1;
  endfunction

endpackage

// File: rtl/gear_field_reg.sv
module gear_field_reg #(
  parameter int unsigned W       = 3,
  parameter int unsigned MAXCODE = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] sel
);
  import clk_gear_pkg::*;

  logic         code_valid;
  logic         take;
  logic [W-1:0] sel_q;

  assign code_valid = code_ok(int'(wdata), MAXCODE);
  assign take       = we && code_valid;

  always_ff @(posedge clk) begin
    if (!rst_n)    sel_q <= '0;
    else if (take) sel_q <= wdata;
  end

  assign sel = sel_q;

  // R3 R5
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !code_valid) |=> $stable(sel_q));

  // R9
  valid_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && code_valid) |=> (sel_q == $past(wdata)));

  // R3 R5
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(sel_q) <= int'(MAXCODE));

endmodule

// File: rtl/gear_div_stage.sv
module gear_div_stage #(
  parameter int unsigned W       = 3,
  parameter int unsigned MAXCODE = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] req,
  output logic         strobe,
  output logic [W-1:0] stat
);
  import clk_gear_pkg::*;

  localparam int unsigned CNT_W = (MAXCODE < 1) ? 1 : MAXCODE;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic [W-1:0]     stat_q;
  logic             boundary;

  // The limit follows the ratio in effect, never the pending request.
  assign lim      = CNT_W'(term_count(int'(stat_q)));
  assign boundary = adv && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      stat_q <= '0;
    end else if (adv) begin
      if (boundary) begin
        cnt_q  <= '0;
        stat_q <= req;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign strobe = boundary;
  assign stat   = stat_q;

  // R7
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(stat_q));

  // R7
  stat_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (stat_q == $past(req)));

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim);

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (cnt_q == '0));

endmodule

// File: rtl/clk_gear_unit.sv
module clk_gear_unit (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [2:0] cfg_gear,
  input  logic [3:0] cfg_pre,
  input  logic [1:0] cfg_mid,
  output logic [2:0] gear_sel,
  output logic [2:0] gear_stat,
  output logic [3:0] pre_sel,
  output logic [3:0] pre_stat,
  output logic [1:0] mid_sel,
  output logic [1:0] mid_stat,
  output logic       gear_en,
  output logic       pre_en,
  output logic       mid_en
);
  import clk_gear_pkg::*;

  logic gear_tick;
  logic pre_tick;
  logic mid_tick;

  gear_field_reg #(.W(GEAR_W), .MAXCODE(GEAR_MAXCODE)) u_gear_reg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_gear), .sel(gear_sel));

  gear_field_reg #(.W(PRE_W), .MAXCODE(PRE_MAXCODE)) u_pre_reg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_pre), .sel(pre_sel));

  gear_field_reg #(.W(MID_W), .MAXCODE(MID_MAXCODE)) u_mid_reg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_mid), .sel(mid_sel));

  gear_div_stage #(.W(GEAR_W), .MAXCODE(GEAR_MAXCODE)) u_gear_div (
    .clk(clk), .rst_n(rst_n), .adv(1'b1), .req(gear_sel),
    .strobe(gear_tick), .stat(gear_stat));

  gear_div_stage #(.W(PRE_W), .MAXCODE(PRE_MAXCODE)) u_pre_div (
    .clk(clk), .rst_n(rst_n), .adv(1'b1), .req(pre_sel),
    .strobe(pre_tick), .stat(pre_stat));

  // The middle stage counts prescaler strobes, not base cycles.
  gear_div_stage #(.W(MID_W), .MAXCODE(MID_MAXCODE)) u_mid_div (
    .clk(clk), .rst_n(rst_n), .adv(pre_tick), .req(mid_sel),
    .strobe(mid_tick), .stat(mid_stat));

  assign gear_en = gear_tick;
  assign pre_en  = pre_tick;
  assign mid_en  = mid_tick;

  // R6
  mid_in_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mid_tick |-> pre_tick);

  // R6
  mid_stat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_tick |=> $stable(mid_stat));

endmodule

// File: tb/clk_gear_unit_bench.sv
module clk_gear_unit_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_gear = '0;
  logic [3:0] cfg_pre = '0;
  logic [1:0] cfg_mid = '0;
  logic [2:0] gear_sel, gear_stat;
  logic [3:0] pre_sel, pre_stat;
  logic [1:0] mid_sel, mid_stat;
  logic       gear_en, pre_en, mid_en;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit mid_bad = 1'b0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && mid_en && !pre_en) mid_bad = 1'b1;

  clk_gear_unit u_clk_gear_unit (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_gear(cfg_gear),
    .cfg_pre(cfg_pre), .cfg_mid(cfg_mid), .gear_sel(gear_sel),
    .gear_stat(gear_stat), .pre_sel(pre_sel), .pre_stat(pre_stat),
    .mid_sel(mid_sel), .mid_stat(mid_stat), .gear_en(gear_en),
    .pre_en(pre_en), .mid_en(mid_en));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int g, input int p, input int m);
    @(negedge clk);
    cfg_gear = 3'(g); cfg_pre = 4'(p); cfg_mid = 2'(m); cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic settle();
    for (int i = 0; i < 6000; i++) begin
      if (gear_stat == gear_sel && pre_stat == pre_sel && mid_stat == mid_sel) return;
      @(negedge clk);
    end
  endtask

  function automatic bit sb(input int k);
    return (k == 0) ? gear_en : (k == 1) ? pre_en : mid_en;
  endfunction

  task automatic measure(input int k, output int per);
    per = 0;
    for (int i = 0; i < 5000 && !sb(k); i++) @(negedge clk);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      per++;
      if (sb(k)) return;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int per, prev, t0, t1, t2;
    bit all1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state and undivided strobes
    all1 = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!(gear_en && pre_en && mid_en)) all1 = 1'b0;
    end
    chk(all1, "R1 strobes", int'(all1), 1);
    chk(gear_sel == 0 && gear_stat == 0, "R1 gear", int'(gear_stat), 0);
    chk(pre_sel == 0 && pre_stat == 0, "R1 pre", int'(pre_stat), 0);
    chk(mid_sel == 0 && mid_stat == 0, "R1 mid", int'(mid_stat), 0);

    // R2 R3 R9: gear sweep
    prev = 0;
    for (int g = 0; g < 8; g++) begin
      wr(g, g % 3, 0);
      chk(int'(pre_sel) == g % 3, "R9 pre beside gear", int'(pre_sel), g % 3);
      settle();
      if (g <= 4) begin
        prev = g;
        chk(int'(gear_stat) == g, "R2 status", int'(gear_stat), g);
      end else begin
        chk(int'(gear_sel) == prev, "R3 sel kept", int'(gear_sel), prev);
        chk(int'(gear_stat) == prev, "R3 stat kept", int'(gear_stat), prev);
      end
      measure(0, per);
      chk(per == (1 << prev), (g <= 4) ? "R2 period" : "R3 period", per, 1 << prev);
    end

    // R4 R5 R9: prescaler sweep
    prev = 0;
    for (int p = 0; p < 16; p++) begin
      wr(p % 5, p, 0);
      chk(int'(gear_sel) == p % 5, "R9 gear beside pre", int'(gear_sel), p % 5);
      settle();
      if (p <= 9) begin
        prev = p;
        chk(int'(pre_stat) == p, "R4 status", int'(pre_stat), p);
      end else begin
        chk(int'(pre_sel) == prev, "R5 sel kept", int'(pre_sel), prev);
        chk(int'(pre_stat) == prev, "R5 stat kept", int'(pre_stat), prev);
      end
      measure(1, per);
      chk(per == (1 << prev), (p <= 9) ? "R4 period" : "R5 period", per, 1 << prev);
    end

    // R6: middle sweep on prescaler /4 and /1
    for (int m = 0; m < 4; m++) begin
      wr(0, 2, m);
      settle();
      chk(int'(mid_stat) == m, "R6 status", int'(mid_stat), m);
      measure(2, per);
      chk(per == (4 << m), "R6 period", per, 4 << m);
    end
    wr(0, 0, 3);
    settle();
    measure(2, per);
    chk(per == 8, "R6 period pre1", per, 8);
    chk(!mid_bad, "R6 mid inside pre", int'(mid_bad), 0);

    // R7 R8: switch /16 -> /2 in mid-period
    wr(4, 0, 0);
    settle();
    for (int i = 0; i < 100 && !gear_en; i++) @(negedge clk);
    @(negedge clk);
    t0 = cyc - 1;
    wr(1, 0, 0);
    chk(gear_sel == 3'd1, "R7 sel now", int'(gear_sel), 1);
    chk(gear_stat == 3'd4, "R7 stat lags", int'(gear_stat), 4);
    for (int i = 0; i < 100 && !gear_en; i++) @(negedge clk);
    t1 = cyc;
    chk(gear_stat == 3'd4, "R7 stat at boundary", int'(gear_stat), 4);
    chk(t1 - t0 == 16, "R8 old interval", t1 - t0, 16);
    @(negedge clk);
    chk(gear_stat == 3'd1, "R7 stat after boundary", int'(gear_stat), 1);
    for (int i = 0; i < 100 && !gear_en; i++) @(negedge clk);
    t2 = cyc;
    chk(t2 - t1 == 2, "R8 new interval", t2 - t1, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule